// File: doc/BRIEF.md
# Indexed Host Port with Streaming Packet-Memory Access

This block sits between a local processor bus and a chip's internal registers and packet SRAM. The host sees only two locations, chosen by a command pin. One location is the index port, which holds a register number. The other is the data port, which reads or writes the register that the index selects. A host always writes the index first and then accesses the data port as often as it needs to.

Three index values open a stream into a byte-addressed packet SRAM of 16 KB. The area 0x0000–0x0BFF holds outgoing frames and 0x0C00–0x3FFF holds incoming frames. One shared pointer addresses the SRAM. The host loads it through two byte registers. Reads go through a one-entry read-ahead buffer. A peek command returns whatever the buffer already holds and refills it from the pointer. After that, each stream read returns the buffered data, steps the pointer and fetches the next location. Stream writes store directly at the pointer and then step it. The step is 1 in 8-bit bus mode and 2 in 16-bit mode. A wrap-enable bit keeps write streams inside the transmit area and read streams inside the receive area.

Top module: `ixp_access_unit`

## Requirements
- R1: With `cmd`=0 an access reaches the index port: a write latches `din[7:0]` as the register index, and a read returns that index on `dout[7:0]`. With `cmd`=1 the access reaches the register named by the index.
- R2: Chip select is active when `cs_in` equals `cs_pol` (`cs_pol`=0 means active low). Strobes while chip select is inactive change nothing.
- R3: Index 0x1F is the mode register and reads back what was written. Bit 7 of this register is the wrap enable. Any index that has no register reads 0x00 and ignores writes.
- R4: Index 0xF4 holds pointer bits [7:0] and index 0xF5 holds pointer bits [13:8] (read with bits 7:6 as zero). Writing either index reloads that part of the pointer, and reading either index returns the current pointer.
- R5: A data read at index 0xF0 (peek) returns the current buffer contents, loads the buffer from the SRAM at the pointer, and leaves the pointer unchanged.
- R6: A data read at index 0xF2 returns the buffer contents, advances the pointer by 1 (8-bit mode) or 2 (16-bit mode), and loads the buffer from the new pointer.
- R7: A data write at index 0xF8 stores the data at the pointer (one byte in 8-bit mode, two bytes low-first in 16-bit mode) and advances the pointer by the same step.
- R8: With wrap enabled, a write that steps the pointer from within 0x0000–0x0BFF past 0x0BFF sets it to 0x0000. With wrap disabled the pointer continues to 0x0C00.
- R9: With wrap enabled, a stream read that steps past 0x3FFF sets the pointer to 0x0C00. With wrap disabled the pointer rolls over to 0x0000.
- R10: Loading either pointer byte clears the read-ahead buffer to zero, so a peek that follows it returns 0x0000.
- R11: In 8-bit mode (`bus_wide`=0) every read returns `dout[15:8]` as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_pol | input | 1 | Chip-select polarity (0: active low) |
| cs_in | input | 1 | Chip select |
| cmd | input | 1 | 0: index port, 1: data port |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| bus_wide | input | 1 | 1: 16-bit bus mode, 0: 8-bit |
| din | input | 16 | Host write data |
| dout | output | 16 | Host read data, registered at the strobe edge |
| mem_addr | output | 14 | SRAM byte address |
| mem_rd | output | 1 | SRAM read request (data valid one cycle later) |
| mem_wr | output | 1 | SRAM write request |
| mem_wide | output | 1 | SRAM access is two bytes |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data {byte at addr+1, byte at addr} |

## Verification
The bench builds the block with its default parameters: a 14-bit pointer, the boundary between the two areas at 0x0BFF/0x0C00, and the wrap logic present. With these values both real wrap points can be reached, at the end of the transmit area and at the top of the SRAM. The bench starts streams a single step before each boundary in both bus modes, and repeats them with wrap disabled to see the plain rollover. Its SRAM model returns a pattern computed from each address, so a stale peek, a correct prefetch and a wrong step each show up as a different value.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
   localparam logic [7:0] IX_MODE    = 8'h1F;
   localparam logic [7:0] IX_PTR_LO  = 8'hF4;
   localparam logic [7:0] IX_PTR_HI  = 8'hF5;
   localparam logic [7:0] IX_PEEK    = 8'hF0;
   localparam logic [7:0] IX_STRM_RD = 8'hF2;
   localparam logic [7:0] IX_STRM_WR = 8'hF8;
   localparam int         WRAP_BIT   = 7;

   typedef struct packed {
      logic idx_wr;
      logic idx_rd;
      logic dat_wr;
      logic dat_rd;
   } ixp_ev_t;
endpackage

// File: rtl/ixp_bus_decode.sv
module ixp_bus_decode
   import ixp_pkg::*;
(
   input  logic    cs_pol,
   input  logic    cs_in,
   input  logic    cmd,
   input  logic    rd_stb,
   input  logic    wr_stb,
   output ixp_ev_t ev
);
   logic sel;

   always_comb begin
      sel       = cs_pol ? cs_in : ~cs_in;
      ev.idx_wr = sel & ~cmd & wr_stb;
      ev.idx_rd = sel & ~cmd & rd_stb;
      ev.dat_wr = sel &  cmd & wr_stb;
      ev.dat_rd = sel &  cmd & rd_stb;
   end
endmodule

// File: rtl/ixp_ptr_unit.sv
module ixp_ptr_unit #(
   parameter int          ADDR_W   = 14,
   parameter int unsigned TX_LAST  = 'h0BFF,
   parameter int unsigned RX_BASE  = 'h0C00,
   parameter bit          HAS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [7:0]        ld_byte,
   input  logic              adv_rd,
   input  logic              adv_wr,
   input  logic              wide,
   input  logic              wrap_en,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] nxt_rd,
   output logic [ADDR_W-1:0] nxt_wr
);
   localparam int HI_W = ADDR_W - 8;
   localparam logic [ADDR_W:0]   TX_END_X  = (ADDR_W+1)'(TX_LAST);
   localparam logic [ADDR_W-1:0] TX_END    = ADDR_W'(TX_LAST);
   localparam logic [ADDR_W-1:0] RX_START  = ADDR_W'(RX_BASE);

   logic [ADDR_W:0] sum;

   always_comb begin
      sum = {1'b0, ptr_q} + (wide ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1));
   end

   generate
      if (HAS_WRAP) begin : g_wrap
         always_comb begin
            if (wrap_en && (ptr_q <= TX_END) && (sum > TX_END_X))
               nxt_wr = '0;
            else
               nxt_wr = sum[ADDR_W-1:0];
            if (wrap_en && sum[ADDR_W])
               nxt_rd = RX_START;
            else
               nxt_rd = sum[ADDR_W-1:0];
         end
      end else begin : g_plain
         always_comb begin
            nxt_wr = sum[ADDR_W-1:0];
            nxt_rd = sum[ADDR_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld_lo) begin
         ptr_q[7:0] <= ld_byte;
      end else if (ld_hi) begin
         ptr_q[ADDR_W-1:8] <= ld_byte[HI_W-1:0];
      end else if (adv_rd) begin
         ptr_q <= nxt_rd;
      end else if (adv_wr) begin
         ptr_q <= nxt_wr;
      end
   end
endmodule

// File: rtl/ixp_prefetch.sv
module ixp_prefetch (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fetch,
   input  logic        clear,
   input  logic        wide,
   input  logic [15:0] mem_rdata,
   output logic [15:0] buf_out
);
   logic        pending_q;
   logic [15:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         buf_q     <= '0;
      end else if (clear) begin
         pending_q <= 1'b0;
         buf_q     <= '0;
      end else begin
         pending_q <= fetch;
         if (pending_q)
            buf_q <= mem_rdata;
      end
   end

   always_comb begin
      buf_out = wide ? buf_q : {8'h00, buf_q[7:0]};
   end
endmodule

// File: rtl/ixp_access_unit.sv
module ixp_access_unit
   import ixp_pkg::*;
#(
   parameter int          ADDR_W   = 14,
   parameter int unsigned TX_LAST  = 'h0BFF,
   parameter int unsigned RX_BASE  = 'h0C00,
   parameter bit          HAS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_pol,
   input  logic              cs_in,
   input  logic              cmd,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              bus_wide,
   input  logic [15:0]       din,
   output logic [15:0]       dout,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_wide,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata
);
   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ixp_access_unit: ADDR_W must lie in 9..16");
   end
   if (RX_BASE != TX_LAST + 1) begin : g_bad_split
      $error("ixp_access_unit: RX_BASE must follow TX_LAST");
   end
   if (RX_BASE >= (1 << ADDR_W)) begin : g_bad_rx
      $error("ixp_access_unit: RX_BASE outside the SRAM");
   end

   ixp_ev_t           ev;
   logic [7:0]        idx_q;
   logic [7:0]        mode_q;
   logic [15:0]       host_dout;
   logic [15:0]       buf_out;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] nxt_rd;
   logic [ADDR_W-1:0] nxt_wr;
   logic              ev_peek, ev_read, ev_write;
   logic              ld_lo, ld_hi, rd_any, wrap_en;
   logic [7:0]        reg_val;
   logic              bus_wide_w;

   ixp_bus_decode u_dec (
      .cs_pol (cs_pol),
      .cs_in  (cs_in),
      .cmd    (cmd),
      .rd_stb (rd_stb),
      .wr_stb (wr_stb),
      .ev     (ev)
   );

   always_comb begin
      bus_wide_w = bus_wide;
      ev_peek    = ev.dat_rd && (idx_q == IX_PEEK);
      ev_read    = ev.dat_rd && (idx_q == IX_STRM_RD);
      ev_write   = ev.dat_wr && (idx_q == IX_STRM_WR);
      ld_lo      = ev.dat_wr && (idx_q == IX_PTR_LO);
      ld_hi      = ev.dat_wr && (idx_q == IX_PTR_HI);
      rd_any     = ev.dat_rd | ev.idx_rd;
      wrap_en    = mode_q[WRAP_BIT];
   end

   ixp_ptr_unit #(
      .ADDR_W   (ADDR_W),
      .TX_LAST  (TX_LAST),
      .RX_BASE  (RX_BASE),
      .HAS_WRAP (HAS_WRAP)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (ld_lo),
      .ld_hi   (ld_hi),
      .ld_byte (din[7:0]),
      .adv_rd  (ev_read),
      .adv_wr  (ev_write),
      .wide    (bus_wide_w),
      .wrap_en (wrap_en),
      .ptr_q   (ptr_q),
      .nxt_rd  (nxt_rd),
      .nxt_wr  (nxt_wr)
   );

   ixp_prefetch u_pf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch     (mem_rd),
      .clear     (ld_lo | ld_hi),
      .wide      (bus_wide_w),
      .mem_rdata (mem_rdata),
      .buf_out   (buf_out)
   );

   always_comb begin
      mem_rd    = ev_peek | ev_read;
      mem_wr    = ev_write;
      mem_wide  = bus_wide_w;
      mem_addr  = ev_read ? nxt_rd : ptr_q;
      mem_wdata = bus_wide_w ? din : {8'h00, din[7:0]};
   end

   always_comb begin
      case (idx_q)
         IX_MODE:   reg_val = mode_q;
         IX_PTR_LO: reg_val = ptr_q[7:0];
         IX_PTR_HI: reg_val = {{(8-HI_W){1'b0}}, ptr_q[ADDR_W-1:8]};
         default:   reg_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= 8'h00;
         mode_q    <= 8'h00;
         host_dout <= 16'h0000;
      end else begin
         if (ev.idx_wr)
            idx_q <= din[7:0];
         if (ev.dat_wr && idx_q == IX_MODE)
            mode_q <= din[7:0];
         if (ev.idx_rd)
            host_dout <= {8'h00, idx_q};
         else if (ev_peek || ev_read)
            host_dout <= buf_out;
         else if (ev.dat_rd)
            host_dout <= {8'h00, reg_val};
      end
   end

   assign dout = host_dout;
endmodule

// File: rtl/ixp_access_chk.sv
module ixp_access_chk #(
   parameter int          ADDR_W  = 14,
   parameter int unsigned TX_LAST = 'h0BFF,
   parameter int unsigned RX_BASE = 'h0C00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_peek,
   input logic              ev_read,
   input logic              ev_write,
   input logic              rd_any,
   input logic              bus_wide,
   input logic              wrap_en,
   input logic [ADDR_W-1:0] ptr_q,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [15:0]       dout
);
   localparam logic [ADDR_W-1:0] TX_END   = ADDR_W'(TX_LAST);
   localparam logic [ADDR_W-1:0] RX_START = ADDR_W'(RX_BASE);

   assert_peek_holds_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_peek |=> $stable(ptr_q));

   assert_mem_single_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   assert_read_moves_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_read |=> ptr_q != $past(ptr_q));

   assert_write_moves_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_write |=> ptr_q != $past(ptr_q));

   assert_tx_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_write && wrap_en && ptr_q <= TX_END) |=> ptr_q <= TX_END);

   assert_rx_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_read && wrap_en && ptr_q >= RX_START) |=> ptr_q >= RX_START);

   assert_narrow_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && !bus_wide) |=> dout[15:8] == 8'h00);
endmodule

bind ixp_access_unit ixp_access_chk #(
   .ADDR_W  (ADDR_W),
   .TX_LAST (TX_LAST),
   .RX_BASE (RX_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev_peek  (ev_peek),
   .ev_read  (ev_read),
   .ev_write (ev_write),
   .rd_any   (rd_any),
   .bus_wide (bus_wide),
   .wrap_en  (wrap_en),
   .ptr_q    (ptr_q),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .dout     (dout)
);

// File: tb/ixp_access_unit_tb.sv
module ixp_access_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_pol = 1'b0;
   logic        cs_in = 1'b1;
   logic        cmd = 1'b0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic        bus_wide = 1'b0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic [13:0] mem_addr;
   logic        mem_rd, mem_wr, mem_wide;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ixp_access_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cs_pol(cs_pol), .cs_in(cs_in), .cmd(cmd),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_wide(bus_wide), .din(din),
      .dout(dout), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // SRAM model: unwritten bytes return a pattern of their address
   logic [7:0] smem [int unsigned];

   function automatic logic [7:0] pat(input logic [13:0] a);
      return (a[7:0] * 8'd3) ^ {2'b10, a[13:8]};
   endfunction

   function automatic logic [7:0] sbyte(input logic [13:0] a);
      if (smem.exists(32'(a))) return smem[32'(a)];
      return pat(a);
   endfunction

   always @(posedge clk) begin
      if (mem_rd)
         mem_rdata <= {sbyte(mem_addr + 14'd1), sbyte(mem_addr)};
      if (mem_wr) begin
         smem[32'(mem_addr)] = mem_wdata[7:0];
         if (mem_wide) smem[32'(mem_addr + 14'd1)] = mem_wdata[15:8];
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic c, input logic [15:0] d);
      @(negedge clk);
      cs_in = cs_pol; cmd = c; din = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cs_in = ~cs_pol;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_rd(input logic c, output logic [15:0] d);
      @(negedge clk);
      cs_in = cs_pol; cmd = c; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0; cs_in = ~cs_pol;
      repeat (3) @(negedge clk);
      d = dout;
   endtask

   task automatic set_reg(input logic [7:0] ix, input logic [15:0] v);
      bus_wr(1'b0, {8'h00, ix});
      bus_wr(1'b1, v);
   endtask

   task automatic get_reg(input logic [7:0] ix, output logic [15:0] v);
      bus_wr(1'b0, {8'h00, ix});
      bus_rd(1'b1, v);
   endtask

   task automatic set_ptr(input logic [13:0] p);
      set_reg(8'hF4, {8'h00, p[7:0]});
      set_reg(8'hF5, {10'h000, p[13:8]});
   endtask

   task automatic get_ptr(output logic [15:0] p);
      logic [15:0] lo, hi;
      get_reg(8'hF4, lo);
      get_reg(8'hF5, hi);
      p = {hi[7:0], lo[7:0]};
   endtask

   function automatic logic [15:0] wd(input logic [13:0] a);
      return {pat(a + 14'd1), pat(a)};
   endfunction

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 reset dout", dout, 16'h0000);
      bus_rd(1'b0, v);
      chk("R1 reset index", v, 16'h0000);
   endtask

   task automatic t_index();
      logic [15:0] v;
      bus_wr(1'b0, 16'h005C);
      bus_rd(1'b0, v);
      chk("R1 index readback", v, 16'h005C);
   endtask

   task automatic t_chip_select();
      logic [15:0] v;
      @(negedge clk);
      cs_in = 1'b1; cmd = 1'b0; din = 16'h0033; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      repeat (2) @(negedge clk);
      bus_rd(1'b0, v);
      chk("R2 inactive select ignored", v, 16'h005C);
      cs_pol = 1'b1; cs_in = 1'b0;
      bus_wr(1'b0, 16'h0021);
      bus_rd(1'b0, v);
      chk("R2 active-high select", v, 16'h0021);
      cs_pol = 1'b0; cs_in = 1'b1;
   endtask

   task automatic t_regs();
      logic [15:0] v;
      set_reg(8'h1F, 16'h0080);
      get_reg(8'h1F, v);
      chk("R3 mode readback", v, 16'h0080);
      set_reg(8'h40, 16'h00AA);
      get_reg(8'h40, v);
      chk("R3 unmapped reads zero", v, 16'h0000);
      get_reg(8'h1F, v);
      chk("R3 unmapped write no effect", v, 16'h0080);
      set_reg(8'h1F, 16'h0000);
   endtask

   task automatic t_pointer();
      logic [15:0] v;
      set_ptr(14'h1234);
      get_ptr(v);
      chk("R4 pointer load", v, 16'h1234);
      set_reg(8'hF5, 16'h00FF);
      get_reg(8'hF5, v);
      chk("R4 pointer high masked", v, 16'h003F);
   endtask

   task automatic t_narrow_read();
      logic [15:0] v;
      bus_wide = 1'b0;
      set_ptr(14'h0100);
      bus_wr(1'b0, 16'h00F0);
      bus_rd(1'b1, v);
      chk("R10 peek after pointer load", v, 16'h0000);
      get_ptr(v);
      chk("R5 peek keeps pointer", v, 16'h0100);
      bus_wr(1'b0, 16'h00F2);
      bus_rd(1'b1, v);
      chk("R6 first narrow read", v, {8'h00, pat(14'h0100)});
      chk("R11 narrow upper zero", {8'h00, v[15:8]}, 16'h0000);
      bus_rd(1'b1, v);
      chk("R6 second narrow read", v, {8'h00, pat(14'h0101)});
      get_ptr(v);
      chk("R6 narrow step", v, 16'h0102);
   endtask

   task automatic t_wide_read();
      logic [15:0] v;
      bus_wide = 1'b1;
      set_ptr(14'h0200);
      get_reg(8'hF0, v);
      chk("R5 stale peek", v, 16'h0000);
      get_reg(8'hF2, v);
      chk("R6 wide read", v, wd(14'h0200));
      bus_rd(1'b1, v);
      chk("R6 wide prefetch", v, wd(14'h0202));
      get_ptr(v);
      chk("R6 wide step", v, 16'h0204);
   endtask

   task automatic t_write();
      logic [15:0] v;
      bus_wide = 1'b1;
      set_ptr(14'h0010);
      set_reg(8'hF8, 16'hBEEF);
      get_ptr(v);
      chk("R7 wide write step", v, 16'h0012);
      set_ptr(14'h0010);
      get_reg(8'hF0, v);
      get_reg(8'hF2, v);
      chk("R7 wide write data", v, 16'hBEEF);
      bus_wide = 1'b0;
      set_ptr(14'h0020);
      set_reg(8'hF8, 16'h1177);
      get_ptr(v);
      chk("R7 narrow write step", v, 16'h0021);
      set_ptr(14'h0020);
      get_reg(8'hF0, v);
      get_reg(8'hF2, v);
      chk("R7 narrow write data", v, 16'h0077);
   endtask

   task automatic t_wrap_write();
      logic [15:0] v;
      set_reg(8'h1F, 16'h0080);
      bus_wide = 1'b1;
      set_ptr(14'h0BFE);
      set_reg(8'hF8, 16'h1234);
      get_ptr(v);
      chk("R8 wide write wrap", v, 16'h0000);
      bus_wide = 1'b0;
      set_ptr(14'h0BFF);
      set_reg(8'hF8, 16'h0055);
      get_ptr(v);
      chk("R8 narrow write wrap", v, 16'h0000);
      set_reg(8'h1F, 16'h0000);
      bus_wide = 1'b1;
      set_ptr(14'h0BFE);
      set_reg(8'hF8, 16'h4321);
      get_ptr(v);
      chk("R8 no wrap when disabled", v, 16'h0C00);
   endtask

   task automatic t_wrap_read();
      logic [15:0] v;
      set_reg(8'h1F, 16'h0080);
      bus_wide = 1'b1;
      set_ptr(14'h3FFE);
      get_reg(8'hF0, v);
      get_reg(8'hF2, v);
      chk("R9 read before wrap", v, wd(14'h3FFE));
      get_ptr(v);
      chk("R9 read wrap pointer", v, 16'h0C00);
      get_reg(8'hF2, v);
      chk("R9 prefetch after wrap", v, wd(14'h0C00));
      set_reg(8'h1F, 16'h0000);
      bus_wide = 1'b0;
      set_ptr(14'h3FFF);
      get_reg(8'hF0, v);
      get_reg(8'hF2, v);
      get_ptr(v);
      chk("R9 rollover when disabled", v, 16'h0000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_chip_select();
      t_regs();
      t_pointer();
      t_narrow_read();
      t_wide_read();
      t_write();
      t_wrap_write();
      t_wrap_read();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule